// File: doc/BRIEF.md
# Key-Locked Alternate-Function Guard

This block protects the alternate-function selection of a bank of pins against stray software writes. Three registers sit on a simple single-cycle register bus. The first is a lock register that opens only when one exact 32-bit key is written to it. The second is an 8-bit commit mask, and it can be rewritten only while the lock is open. The third is the alternate-function select byte. A write to it changes only the bits whose commit bit is set.

The select byte leaves the block as a plain output and feeds pin multiplexing outside the block. Software reads back the lock state, the commit mask and the select byte through the same bus. Read data is registered and appears in the cycle after the request. An access to any other offset returns zero and raises a one-cycle error flag.

Top module: `cfg_commit_guard`

## Requirements
- R1: After synchronous reset, the block is locked, so the lock register reads 1. The commit mask reads 0xFF, the select output is 0x00, and `bus_rdata` and `bus_err` are 0.
- R2: A write of exactly 0x0ACCE551 to offset 0x520 opens the lock, and the lock register then reads 0.
- R3: A write of any other value to offset 0x520 closes the lock, and the lock register then reads 1. This includes a value that differs from the key in one bit.
- R4: The lock state changes only on a write to offset 0x520. Reads of that offset leave it unchanged, and so do accesses to other offsets, mapped or not.
- R5: A write to offset 0x524 while the lock is open loads the low 8 bits of the data into the commit mask. A write while locked leaves the mask unchanged.
- R6: A write to offset 0x420 replaces only the select bits whose commit bit is 1; the other bits keep their value. The new value is on `af_sel` in the cycle after the write.
- R7: Reads of offsets 0x420 and 0x524 return the 8-bit select byte and the 8-bit commit mask in bits 7:0, with bits 31:8 zero.
- R8: An access to any offset other than 0x420, 0x520 and 0x524, including a misaligned one, has three effects. It reads as zero, it changes no state, and it sets `bus_err` for exactly the one cycle after the access.
- R9: `bus_rdata` carries read data only in the cycle after an accepted read. It is zero in every other cycle, including the cycle after a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Access request, one access per cycle it is high |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after a read |
| bus_err | output | 1 | One-cycle pulse after an access to an unmapped offset |
| af_sel | output | 8 | Alternate-function select byte |

## Verification
The bench writes a key that differs from the real key in its lowest bit. A design that compared only part of the word would open the lock on that write. It writes the commit mask while the lock is closed and checks that the old mask survives; a design that ignored the lock would lose it. Select writes are made under a partial mask, and the bench checks that the uncommitted bits keep their old value rather than clearing or taking the new data. The bench also makes unmapped and misaligned accesses between lock-state reads to catch a decoder that aliases offsets or lets an erroneous access change the lock.

// File: rtl/ccg_pkg.sv
// Shared constants and types for the key-locked alternate-function guard.
// Assumes a 12-bit byte offset space and a 32-bit data bus.
package ccg_pkg;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int CFG_W  = 8;

    localparam logic [ADDR_W-1:0] OFS_AFSEL  = 12'h420;
    localparam logic [ADDR_W-1:0] OFS_LOCK   = 12'h520;
    localparam logic [ADDR_W-1:0] OFS_COMMIT = 12'h524;

    localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h0ACC_E551;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_AF,
        SEL_LOCK,
        SEL_COMMIT
    } reg_sel_e;
endpackage

// File: rtl/ccg_lock.sv
// Lock state holder.
// Compares the full write word against the unlock key on each write to the
// lock offset. The key opens the lock and any other value closes it.
// Assumes wr_en is already qualified by the decoder (request, write, offset).
module ccg_lock #(
    parameter int                 DATA_W = 32,
    parameter logic [DATA_W-1:0]  KEY    = 32'h0ACC_E551
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic              locked
);
    logic key_match;

    // Full-width comparison of the write data with the key.
    always_comb begin
        key_match = (wdata == KEY);
    end

    // Lock flop: set at reset, rewritten only by a lock-offset write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked <= 1'b1;
        end else if (wr_en) begin
            locked <= !key_match;
        end
    end

    AST_LOCK_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(locked)); // R4
    AST_KEY_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wdata == KEY) |=> !locked); // R2
    AST_BAD_KEY_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wdata != KEY) |=> locked); // R3
endmodule

// File: rtl/ccg_commit.sv
// Commit mask register.
// Loads the low CFG_W bits of a write only while the lock is open.
// Assumes wr_en is qualified by the decoder and locked is the current state.
module ccg_commit #(
    parameter int CFG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             locked,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] commit
);
    // Mask register: all ones at reset, writable only when unlocked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            commit <= '1;
        end else if (wr_en && !locked) begin
            commit <= wdata;
        end
    end

    AST_COMMIT_FROZEN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && locked) |=> $stable(commit)); // R5
    AST_COMMIT_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(commit)); // R5
endmodule

// File: rtl/ccg_afsel.sv
// Alternate-function select register with per-bit write gating.
// Each bit takes the write data only when its commit bit is set.
// Assumes wr_en is qualified by the decoder; commit is the current mask.
module ccg_afsel #(
    parameter int CFG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] commit,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] af
);
    genvar b;
    generate
        for (b = 0; b < CFG_W; b++) begin : g_bit
            // One select bit: cleared at reset, loaded when written and committed.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    af[b] <= 1'b0;
                end else if (wr_en && commit[b]) begin
                    af[b] <= wdata[b];
                end
            end
        end
    endgenerate

    AST_AF_UNCOMMITTED_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((af ^ $past(af)) & ~$past(commit)) == '0); // R6
    AST_AF_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(af)); // R6
endmodule

// File: rtl/cfg_commit_guard.sv
// Top of the key-locked alternate-function guard.
// Decodes the register bus, routes write strobes to the lock, commit and
// select registers, and registers read data and the unmapped-access error.
// Assumes one access per cycle with bus_req high and no wait states.
module cfg_commit_guard
    import ccg_pkg::*;
#(
    parameter int ADDR_W = ccg_pkg::ADDR_W,
    parameter int DATA_W = ccg_pkg::DATA_W,
    parameter int CFG_W  = ccg_pkg::CFG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_err,
    output logic [CFG_W-1:0]  af_sel
);
    localparam int PAD_CFG  = DATA_W - CFG_W;
    localparam int PAD_LOCK = DATA_W - 1;

    reg_sel_e          sel;
    logic              wr_af, wr_lock, wr_commit;
    logic              locked;
    logic [CFG_W-1:0]  commit;
    logic [DATA_W-1:0] rd_next;

    // Offset decode: exact match on the full byte offset.
    always_comb begin
        sel = SEL_NONE;
        if (bus_addr == ADDR_W'(OFS_AFSEL))  sel = SEL_AF;
        if (bus_addr == ADDR_W'(OFS_LOCK))   sel = SEL_LOCK;
        if (bus_addr == ADDR_W'(OFS_COMMIT)) sel = SEL_COMMIT;
    end

    // Write strobes for each register.
    always_comb begin
        wr_af     = bus_req && bus_we && (sel == SEL_AF);
        wr_lock   = bus_req && bus_we && (sel == SEL_LOCK);
        wr_commit = bus_req && bus_we && (sel == SEL_COMMIT);
    end

    ccg_lock #(
        .DATA_W (DATA_W),
        .KEY    (DATA_W'(UNLOCK_KEY))
    ) u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_lock),
        .wdata  (bus_wdata),
        .locked (locked)
    );

    ccg_commit #(
        .CFG_W (CFG_W)
    ) u_commit (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_commit),
        .locked (locked),
        .wdata  (bus_wdata[CFG_W-1:0]),
        .commit (commit)
    );

    ccg_afsel #(
        .CFG_W (CFG_W)
    ) u_afsel (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_af),
        .commit (commit),
        .wdata  (bus_wdata[CFG_W-1:0]),
        .af     (af_sel)
    );

    // Read multiplexer: zero-extended register values, zero when unmapped.
    always_comb begin
        unique case (sel)
            SEL_AF:     rd_next = {{PAD_CFG{1'b0}}, af_sel};
            SEL_LOCK:   rd_next = {{PAD_LOCK{1'b0}}, locked};
            SEL_COMMIT: rd_next = {{PAD_CFG{1'b0}}, commit};
            default:    rd_next = '0;
        endcase
    end

    // Response registers: read data for reads only, error for unmapped hits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
            bus_err   <= 1'b0;
        end else begin
            bus_rdata <= (bus_req && !bus_we) ? rd_next : '0;
            bus_err   <= bus_req && (sel == SEL_NONE);
        end
    end

    AST_ERR_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_req |=> !bus_err); // R8
    AST_UNMAPPED_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && sel == SEL_NONE) |=> ($stable(locked) && $stable(commit) && $stable(af_sel))); // R8
    AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_req && !bus_we) |=> bus_rdata == '0); // R9
    AST_CFG_READ_PADDED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && (sel == SEL_AF || sel == SEL_COMMIT)) |=> bus_rdata[DATA_W-1:CFG_W] == '0); // R7
endmodule

// File: tb/sim_cfg_commit_guard.sv
// Scoreboard bench: the access task queues the expected response of every
// access, and a monitor pops and compares it in the cycle the design answers.
module sim_cfg_commit_guard;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic [7:0]  af_sel;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;
    logic took_q = 1'b0;

    typedef struct {
        logic [31:0] rdata;
        logic        err;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    cfg_commit_guard u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_err   (bus_err),
        .af_sel    (af_sel)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: one access, expected response pushed to the scoreboard.
    task automatic access(bit we, logic [11:0] addr, logic [31:0] wd,
                          logic [31:0] exp_rd, bit exp_err, string tag);
        exp_t e;
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_addr = addr; bus_wdata = wd;
        e.rdata = exp_rd; e.err = exp_err; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    endtask

    // Notes whether the design accepted an access at this edge.
    always @(posedge clk) took_q <= bus_req && rst_n;

    // Monitor: compare responses away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (took_q) begin
                if (sb.size() == 0) begin
                    checks++; fails++;
                    $display("FAIL R9 actual=unexpected response expected=none");
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk({e.tag, " rdata"}, bus_rdata, e.rdata);
                    chk({e.tag, " err"}, {31'b0, bus_err}, {31'b0, e.err});
                end
            end else begin
                chk("R9 idle rdata", bus_rdata, 32'h0);
                chk("R8 idle err", {31'b0, bus_err}, 32'h0);
            end
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 af_sel", {24'b0, af_sel}, 32'h0);
        chk("R1 rdata", bus_rdata, 32'h0);
        access(0, 12'h520, 0, 32'h1, 0, "R1 lock");
        access(0, 12'h524, 0, 32'hFF, 0, "R1 commit");
        access(0, 12'h420, 0, 32'h0, 0, "R1 af");
        // Full mask at reset: whole byte written even while locked.
        access(1, 12'h420, 32'hFFFF_FF5A, 32'h0, 0, "R6 write");
        chk("R6 af_sel", {24'b0, af_sel}, 32'h5A);
        access(0, 12'h420, 0, 32'h5A, 0, "R7 af read");
        // Commit write while locked is dropped.
        access(1, 12'h524, 32'h0F, 32'h0, 0, "R5 locked write");
        access(0, 12'h524, 0, 32'hFF, 0, "R5 commit kept");
        // Near-miss key keeps it locked.
        access(1, 12'h520, 32'h0ACC_E550, 32'h0, 0, "R3 near key");
        access(0, 12'h520, 0, 32'h1, 0, "R3 still locked");
        access(1, 12'h520, 32'h0ACC_E551, 32'h0, 0, "R2 key");
        access(0, 12'h520, 0, 32'h0, 0, "R2 unlocked");
        // Unmapped and misaligned accesses: zero, error, no state change.
        access(0, 12'h41C, 0, 32'h0, 1, "R8 unmapped read");
        access(0, 12'h520, 0, 32'h0, 0, "R4 after read");
        access(1, 12'h600, 32'h1234_5678, 32'h0, 1, "R8 unmapped write");
        access(1, 12'h521, 32'hDEAD_BEEF, 32'h0, 1, "R8 misaligned write");
        access(0, 12'h520, 0, 32'h0, 0, "R4 after bad writes");
        chk("R8 af_sel", {24'b0, af_sel}, 32'h5A);
        // Unlocked commit write takes low byte only.
        access(1, 12'h524, 32'hFFFF_FF0F, 32'h0, 0, "R5 open write");
        access(0, 12'h524, 0, 32'h0F, 0, "R7 commit read");
        access(1, 12'h420, 32'h0000_00A5, 32'h0, 0, "R6 masked");
        chk("R6 partial", {24'b0, af_sel}, 32'h55);
        access(1, 12'h420, 32'h0, 32'h0, 0, "R4 af write");
        access(0, 12'h520, 0, 32'h0, 0, "R4 lock after af");
        chk("R6 low cleared", {24'b0, af_sel}, 32'h50);
        // Relock with arbitrary value.
        access(1, 12'h520, 32'h1234_5678, 32'h0, 0, "R3 relock");
        access(0, 12'h520, 0, 32'h1, 0, "R3 locked");
        access(1, 12'h524, 32'hFF, 32'h0, 0, "R5 relocked write");
        access(0, 12'h524, 0, 32'h0F, 0, "R5 mask held");
        access(1, 12'h420, 32'hAF, 32'h0, 0, "R6 relocked af");
        chk("R6 locked mask", {24'b0, af_sel}, 32'h5F);
        access(0, 12'h420, 0, 32'h5F, 0, "R7 af padded");
        // Reset in the middle of operation.
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 af after reset", {24'b0, af_sel}, 32'h0);
        access(0, 12'h520, 0, 32'h1, 0, "R1 relocked");
        access(0, 12'h524, 0, 32'hFF, 0, "R1 mask restored");
        repeat (2) @(negedge clk);
        if (sb.size() != 0) begin
            checks++; fails++;
            $display("FAIL R9 actual=%0d pending expected=0", sb.size());
        end
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule